// File: doc/BRIEF.md
# Paged Address Translator with Associative Frame Cache

This block turns a word address issued by a processor into a physical memory address under a paging scheme. The logical address splits into a page number (upper bits) and an offset (lower bits). The page number is looked up in a small set of associative registers, each holding a page and frame pair. All of these registers are compared in the same cycle. A hit produces the frame at once. The physical address is the frame number placed above the unchanged offset bits.

On a lookup miss, the page number is first checked against a programmable table-length register. An out-of-range page ends the request with an error and touches no memory. An in-range page makes the block read the table entry from memory at the table base register plus the page number. The fetched frame goes into the associative registers, filled in round-robin order, and the data access is then issued. A hit therefore costs one memory transfer and a miss costs two.

The processor holds its request until the block returns a one-cycle completion pulse. A configuration port writes the base and length registers, and any such write empties the associative registers.

Top module: `pgx_top`

## Requirements
- R1: After reset, no completion pulse and no memory request are present, and the associative registers hold no entries, so the first access to any page misses.
- R2: The physical address of a data access is the frame number in bits [6:3] and the logical offset (logical address bits [2:0]) in bits [2:0]; the page number is logical address bits [4:3].
- R3: On a miss with a page number below the length register, exactly two memory transfers occur: a read at base + page, whose bits [3:0] give the frame, followed by the data access.
- R4: On a hit, exactly one memory transfer occurs, the data access, and no table read is made.
- R5: On a miss with a page number greater than or equal to the length register, the request completes with the error output high and no memory transfer.
- R6: A table entry fetched on a miss replaces the associative registers in round-robin order starting at entry 0, so with two entries a third distinct page evicts the first one filled.
- R7: A write to the base register (cfg_sel = 0) or to the length register (cfg_sel = 1) empties all associative registers, so the next access to a previously cached page misses.
- R8: A memory request holds valid and its address steady until ready is seen. A read returns mem_rdata on cpu_rdata with a one-cycle cpu_done pulse. A write drives mem_we high with cpu_wdata on mem_wdata.
- R9: At most one associative register matches a given page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the table base, 1 selects the table length |
| cfg_wdata | input | 7 | Configuration write value |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | Request is a write |
| cpu_laddr | input | 5 | Logical word address |
| cpu_wdata | input | 8 | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Page out of range, valid with cpu_done |
| cpu_rdata | output | 8 | Read data, valid with cpu_done |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 7 | Physical memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_ready | input | 1 | Memory accepts the transfer; read data valid |
| mem_rdata | input | 8 | Memory read data |

## Verification
The hardest situation to reach is eviction: a page must be replaced while other pages stay cached, and this is seen only through the number of memory transfers. The stimulus fills both entries with pages 0 and 1, then touches page 2 to evict page 0. It next touches page 2 again and page 1, and checks that these hit. Page 0 is then touched to confirm that it misses and pushes out the next entry in rotation. Each request is classified as a hit or a miss by counting the transfers seen on the memory port and logging their addresses.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_WALK,
    S_DATA,
    S_RESP
  } xl_state_e;
endpackage

// File: rtl/pgx_cfg.sv
module pgx_cfg #(
  parameter int MA_W  = 7,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [MA_W-1:0]  cfg_wdata,
  output logic [MA_W-1:0]  tbl_base,
  output logic [LEN_W-1:0] tbl_len,
  output logic             flush
);
  logic [MA_W-1:0]  base_q, base_d;
  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    base_d = base_q;
    len_d  = len_q;
    if (cfg_we && !cfg_sel) base_d = cfg_wdata;
    if (cfg_we &&  cfg_sel) len_d  = cfg_wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else if (cfg_we) begin
      base_q <= base_d;
      len_q  <= len_d;
    end
  end

  assign tbl_base = base_q;
  assign tbl_len  = len_q;
  assign flush    = cfg_we;
endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
  parameter int N       = 2,
  parameter int PAGE_W  = 2,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [FRAME_W-1:0] fill_frame
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]              vld_q, vld_d;
  logic [N-1:0][PAGE_W-1:0]  pg_q, pg_d;
  logic [N-1:0][FRAME_W-1:0] fr_q, fr_d;
  logic [PTR_W-1:0]          ptr_q, ptr_d;
  logic [N-1:0]              match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = vld_q[i] && (pg_q[i] == lk_page);
  end

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) lk_frame = lk_frame | fr_q[i];
  end
  assign lk_hit = |match;

  always_comb begin
    vld_d = vld_q;
    pg_d  = pg_q;
    fr_d  = fr_q;
    ptr_d = ptr_q;
    if (flush) begin
      vld_d = '0;
      ptr_d = '0;
    end else if (fill_en) begin
      vld_d[ptr_q] = 1'b1;
      pg_d[ptr_q]  = lk_page;
      fr_d[ptr_q]  = fill_frame;
      ptr_d = (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      pg_q  <= '0;
      fr_q  <= '0;
      ptr_q <= '0;
    end else if (flush || fill_en) begin
      vld_q <= vld_d;
      pg_q  <= pg_d;
      fr_q  <= fr_d;
      ptr_q <= ptr_d;
    end
  end

  // R9: parallel compare yields at most one match
  p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R7: configuration write empties every entry
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
  import pgx_pkg::*;
#(
  parameter int PAGE_W  = 2,
  parameter int OFF_W   = 3,
  parameter int FRAME_W = 4,
  parameter int DATA_W  = 8,
  parameter int MA_W    = FRAME_W + OFF_W,
  parameter int LEN_W   = PAGE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [PAGE_W+OFF_W-1:0] cpu_laddr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_done,
  output logic                    cpu_err,
  output logic [DATA_W-1:0]       cpu_rdata,
  input  logic [MA_W-1:0]         tbl_base,
  input  logic [LEN_W-1:0]        tbl_len,
  output logic [PAGE_W-1:0]       lk_page,
  input  logic                    lk_hit,
  input  logic [FRAME_W-1:0]      lk_frame,
  output logic                    fill_en,
  output logic [FRAME_W-1:0]      fill_frame,
  output logic                    mem_valid,
  output logic                    mem_we,
  output logic [MA_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic                    mem_ready,
  input  logic [DATA_W-1:0]       mem_rdata
);
  xl_state_e          st_q, st_d;
  logic [PAGE_W-1:0]  page_q, page_d;
  logic [OFF_W-1:0]   off_q, off_d;
  logic               we_q, we_d, err_q, err_d;
  logic [DATA_W-1:0]  wd_q, wd_d, rd_q, rd_d;
  logic [FRAME_W-1:0] fr_q, fr_d;
  logic               out_rng;

  assign out_rng = {1'b0, page_q} >= tbl_len;

  always_comb begin
    st_d   = st_q;
    page_d = page_q;
    off_d  = off_q;
    we_d   = we_q;
    wd_d   = wd_q;
    rd_d   = rd_q;
    fr_d   = fr_q;
    err_d  = err_q;
    unique case (st_q)
      S_IDLE: if (cpu_req) begin
        page_d = cpu_laddr[PAGE_W+OFF_W-1:OFF_W];
        off_d  = cpu_laddr[OFF_W-1:0];
        we_d   = cpu_we;
        wd_d   = cpu_wdata;
        err_d  = 1'b0;
        st_d   = S_LOOK;
      end
      S_LOOK: begin
        if (lk_hit) begin
          fr_d = lk_frame;
          st_d = S_DATA;
        end else if (out_rng) begin
          err_d = 1'b1;
          st_d  = S_RESP;
        end else begin
          st_d = S_WALK;
        end
      end
      S_WALK: if (mem_ready) begin
        fr_d = mem_rdata[FRAME_W-1:0];
        st_d = S_DATA;
      end
      S_DATA: if (mem_ready) begin
        rd_d = mem_rdata;
        st_d = S_RESP;
      end
      S_RESP: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      page_q <= '0;
      off_q  <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
      fr_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      page_q <= page_d;
      off_q  <= off_d;
      we_q   <= we_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
      fr_q   <= fr_d;
      err_q  <= err_d;
    end
  end

  assign lk_page    = page_q;
  assign fill_en    = (st_q == S_WALK) && mem_ready;
  assign fill_frame = mem_rdata[FRAME_W-1:0];
  assign mem_valid  = (st_q == S_WALK) || (st_q == S_DATA);
  assign mem_we     = (st_q == S_DATA) && we_q;
  assign mem_wdata  = wd_q;
  assign mem_addr   = (st_q == S_WALK) ? (tbl_base + MA_W'(page_q)) : {fr_q, off_q};
  assign cpu_done   = (st_q == S_RESP);
  assign cpu_err    = err_q;
  assign cpu_rdata  = rd_q;

  // R8: request held steady until accepted
  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  // R5: out-of-range miss completes at once with no memory transfer
  p_range_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LOOK && !lk_hit && out_rng) |=> (cpu_done && cpu_err && !mem_valid));
  // R3: table read is followed by the data access in the fetched frame
  p_walk_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WALK && mem_ready) |=>
      (mem_valid && mem_addr[MA_W-1:OFF_W] == $past(mem_rdata[FRAME_W-1:0])));
endmodule

// File: rtl/pgx_top.sv
module pgx_top #(
  parameter int PAGE_W  = 2,
  parameter int OFF_W   = 3,
  parameter int FRAME_W = 4,
  parameter int DATA_W  = 8,
  parameter int TLB_N   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic                          cfg_sel,
  input  logic [FRAME_W+OFF_W-1:0]      cfg_wdata,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [PAGE_W+OFF_W-1:0]       cpu_laddr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic                          cpu_done,
  output logic                          cpu_err,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic                          mem_valid,
  output logic                          mem_we,
  output logic [FRAME_W+OFF_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic                          mem_ready,
  input  logic [DATA_W-1:0]             mem_rdata
);
  localparam int MA_W  = FRAME_W + OFF_W;
  localparam int LEN_W = PAGE_W + 1;

  logic [MA_W-1:0]    tbl_base;
  logic [LEN_W-1:0]   tbl_len;
  logic               flush, lk_hit, fill_en;
  logic [PAGE_W-1:0]  lk_page;
  logic [FRAME_W-1:0] lk_frame, fill_frame;

  pgx_cfg #(.MA_W(MA_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tbl_base(tbl_base), .tbl_len(tbl_len), .flush(flush)
  );

  pgx_tlb #(.N(TLB_N), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_page(lk_page),
    .lk_hit(lk_hit), .lk_frame(lk_frame), .fill_en(fill_en), .fill_frame(fill_frame)
  );

  pgx_ctrl #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .DATA_W(DATA_W),
             .MA_W(MA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_laddr(cpu_laddr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
    .cpu_err(cpu_err), .cpu_rdata(cpu_rdata), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .lk_page(lk_page), .lk_hit(lk_hit), .lk_frame(lk_frame), .fill_en(fill_en),
    .fill_frame(fill_frame), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );
endmodule

// File: tb/pgx_top_tb.sv
module pgx_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic       cpu_req = 1'b0, cpu_we = 1'b0;
  logic [4:0] cpu_laddr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_done, cpu_err;
  logic [7:0] cpu_rdata;
  logic       mem_valid, mem_we;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_ready = 1'b0;
  logic [7:0] mem_rdata = '0;

  logic [7:0] mem [128];
  int n_acc;
  logic [6:0] acc_addr [4];
  logic       acc_we [4];
  int checks = 0, fails = 0;
  logic [7:0] got_rd;
  logic       got_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgx_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_laddr(cpu_laddr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // memory model: accepts one cycle after valid is seen
  always @(negedge clk) begin
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_valid) begin
      mem_ready = 1'b1;
      if (n_acc < 4) begin
        acc_addr[n_acc] = mem_addr;
        acc_we[n_acc]   = mem_we;
      end
      n_acc = n_acc + 1;
      if (mem_we) mem[mem_addr] = mem_wdata;
      else        mem_rdata = mem[mem_addr];
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    checks = checks + 1;
    fails  = fails + 1;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  task automatic chk(string req, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic sel, logic [6:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(logic we, logic [1:0] pg, logic [2:0] off, logic [7:0] wd);
    @(negedge clk);
    n_acc = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_laddr = {pg, off}; cpu_wdata = wd;
    do @(negedge clk); while (!cpu_done);
    got_rd = cpu_rdata;
    got_err = cpu_err;
    cpu_req = 1'b0;
  endtask

  // expected physical address from the frame and offset
  function automatic int pa(int fr, int off);
    return fr * 8 + off;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 done low", int'(cpu_done), 0);
    chk("R1 mem idle", int'(mem_valid), 0);
  endtask

  task automatic t_first_misses();
    access(1'b0, 2'd0, 3'd5, 8'h00);
    chk("R1 R3 first miss transfers", n_acc, 2);
    chk("R3 table addr", int'(acc_addr[0]), 112);
    chk("R2 data addr p0", int'(acc_addr[1]), pa(3, 5));
    chk("R8 rdata p0", int'(got_rd), int'(mem[pa(3, 5)]));
    access(1'b0, 2'd1, 3'd0, 8'h00);
    chk("R3 miss p1 transfers", n_acc, 2);
    chk("R3 table addr p1", int'(acc_addr[0]), 113);
    chk("R2 data addr p1", int'(acc_addr[1]), pa(6, 0));
    access(1'b0, 2'd2, 3'd7, 8'h00);
    chk("R3 R6 miss p2 transfers", n_acc, 2);
    chk("R2 data addr p2", int'(acc_addr[1]), pa(4, 7));
    chk("R5 no err in range", int'(got_err), 0);
  endtask

  task automatic t_hits();
    access(1'b0, 2'd2, 3'd1, 8'h00);
    chk("R4 hit p2 transfers", n_acc, 1);
    chk("R4 hit p2 addr", int'(acc_addr[0]), pa(4, 1));
    chk("R4 hit p2 rdata", int'(got_rd), int'(mem[pa(4, 1)]));
    access(1'b1, 2'd1, 3'd3, 8'h5C);
    chk("R4 hit p1 write transfers", n_acc, 1);
    chk("R8 write strobe", int'(acc_we[0]), 1);
    chk("R8 write landed", int'(mem[pa(6, 3)]), 8'h5C);
    access(1'b0, 2'd1, 3'd3, 8'h00);
    chk("R8 readback", int'(got_rd), 8'h5C);
  endtask

  task automatic t_round_robin();
    access(1'b0, 2'd0, 3'd2, 8'h00);
    chk("R6 evicted p0 misses", n_acc, 2);
    access(1'b0, 2'd2, 3'd2, 8'h00);
    chk("R6 p2 kept", n_acc, 1);
    access(1'b0, 2'd1, 3'd2, 8'h00);
    chk("R6 p1 evicted", n_acc, 2);
  endtask

  task automatic t_range_error();
    access(1'b0, 2'd3, 3'd4, 8'h00);
    chk("R5 err flag", int'(got_err), 1);
    chk("R5 no transfer", n_acc, 0);
  endtask

  task automatic t_flush();
    cfg_write(1'b1, 7'd4);
    access(1'b0, 2'd1, 3'd6, 8'h00);
    chk("R7 cached page misses after write", n_acc, 2);
    access(1'b0, 2'd3, 3'd0, 8'h00);
    chk("R5 R7 longer table p3 ok", int'(got_err), 0);
    chk("R3 p3 table addr", int'(acc_addr[0]), 115);
    chk("R2 p3 data addr", int'(acc_addr[1]), pa(9, 0));
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 5 + 7);
    mem[112] = 8'd3; mem[113] = 8'd6; mem[114] = 8'd4; mem[115] = 8'd9;
    n_acc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    cfg_write(1'b0, 7'd112);
    cfg_write(1'b1, 7'd3);
    t_first_misses();
    t_hits();
    t_round_robin();
    t_range_error();
    t_flush();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule